// File: doc/BRIEF.md
# Interrupt Ring Consumer with Fault Prescreen

This block drains a circular buffer of interrupt vectors that some other agent fills. Each vector takes sixteen bytes, as four 32-bit words. The producer's byte write pointer arrives as a plain 32-bit input word that also carries an overflow flag. Whenever the consumer's own byte read pointer differs from the effective write pointer, the block reads the four words of the next vector from a synchronous ring-memory port and splits them into fields. It then hands the result to a downstream consumer over a valid/ready stream.

Vectors that report a page fault (source ids 146 and 147) and name a nonzero address-space id are checked against an external credit port before they go out. A vector the credit port refuses is dropped, and the read pointer moves past it. When the producer reports overflow, the consumer gives up its position and jumps to the oldest vector still intact. It also sends the producer a one-cycle overflow-clear pulse. Each time the ring drains, the updated read pointer is published on a write-back pulse so that the producer can reclaim the space.

Top module: `irq_ring_consumer`

## Requirements
- R1: After synchronous reset the following are all low: `out_valid`, `cred_req_valid`, `mem_rd_en`, `rptr_wb_valid` and `ovf_clear`. The internal read pointer starts at byte 0.
- R2: The effective write pointer is formed in two steps. Bit 0 of `wptr_word` (the overflow flag) is cleared, and the result is cut to the low ADDR_W bits. Bits of `wptr_word` at or above ADDR_W have no effect. When the effective write pointer equals the read pointer, no vector is fetched.
- R3: If bit 0 of `wptr_word` is set while the block is idle, the read pointer becomes (effective write pointer + 16) modulo 2^ADDR_W, and `ovf_clear` pulses for exactly one cycle. Fetching then resumes from the new position. In that idle cycle the overflow takes priority over both a normal fetch and a write-back.
- R4: A vector is read as four words at word indices rptr>>2, +1, +2 and +3, each one modulo the ring depth.
- R5: Decoded fields are taken as follows. Source id is word0[7:0], and source data is word1[27:0]. Ring id is word2[7:0], the virtual-machine id is word2[15:8], and the address-space id is word2[31:16].
- R6: A vector whose source id is 146 or 147 and whose address-space id is nonzero raises `cred_req_valid` with that id on `cred_req_pasid`. The request is held stable until `cred_rsp_valid`. A fault vector with address-space id 0, and any other source id, passes without a request.
- R7: A fault vector whose credit response has `cred_rsp_grant` low is dropped. It never appears on the output, and the read pointer advances by 16.
- R8: An accepted vector is presented on the output. The read pointer advances by 16 only on the cycle where `out_valid` and `out_ready` are both high, and `out_valid` drops on the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, the output fields hold stable and no further vector is fetched.
- R10: When the pointers are equal and the read pointer has changed since the last write-back, `rptr_wb_valid` pulses for one cycle with the read pointer on `rptr_wb`. In all other cases no write-back occurs.
- R11: All read-pointer arithmetic wraps modulo the ring size of 2^ADDR_W bytes, so a vector at the last slot is followed by the vector at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wptr_word | input | 32 | Producer byte write pointer; bit 0 is the overflow flag |
| mem_rd_en | output | 1 | Ring memory read strobe |
| mem_rd_addr | output | ADDR_W-2 (6) | Ring memory word index |
| mem_rd_data | input | 32 | Ring memory read data, one cycle after the strobe |
| cred_req_valid | output | 1 | Credit check request |
| cred_req_pasid | output | 16 | Address-space id to check |
| cred_rsp_valid | input | 1 | Credit response strobe |
| cred_rsp_grant | input | 1 | Credit granted when high |
| out_valid | output | 1 | Decoded vector available |
| out_ready | input | 1 | Downstream accepts the vector |
| out_src_id | output | 8 | Source id |
| out_src_data | output | 28 | Source data |
| out_ring_id | output | 8 | Ring id |
| out_vmid | output | 8 | Virtual-machine id |
| out_pasid | output | 16 | Address-space id |
| rptr_wb_valid | output | 1 | Read pointer write-back strobe |
| rptr_wb | output | ADDR_W (8) | Read pointer being written back |
| ovf_clear | output | 1 | Overflow-clear pulse to the producer |

## Verification
The overflow jump and the read-pointer write-back are both decided in the same idle cycle, and a vector stalled on the output can delay that cycle until an overflow flag is already waiting. The bench holds `out_ready` low on a pending vector, raises the overflow flag, and then releases ready. It expects the stalled vector to complete first and then exactly one clear pulse. After that it expects fifteen vectors from the jump target in ring order, and only then a single write-back of the drained pointer. Any extra clear pulse, an early write-back, or a wrong first vector after the jump is reported.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

    localparam int WORD_W        = 32;
    localparam int WORDS_PER_VEC = 4;
    localparam int VEC_BYTES     = 16;
    localparam int OVF_BIT       = 0;

    localparam logic [7:0] SRC_FAULT_A = 8'd146;
    localparam logic [7:0] SRC_FAULT_B = 8'd147;

    typedef logic [WORDS_PER_VEC-1:0][WORD_W-1:0] vec_words_t;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vmid;
        logic [15:0] pasid;
    } irq_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SCREEN,
        ST_CREDIT,
        ST_EMIT
    } cons_state_t;

    function automatic logic is_fault_src(input logic [7:0] id);
        return (id == SRC_FAULT_A) || (id == SRC_FAULT_B);
    endfunction

endpackage

// File: rtl/irq_wptr_cond.sv
module irq_wptr_cond
    import irq_ring_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic [ADDR_W-1:0] wptr_eff,
    output logic [ADDR_W-1:0] jump_ptr
);
    localparam logic [ADDR_W-1:0] FLAG_MASK = ADDR_W'(1) << OVF_BIT;
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(VEC_BYTES);

    logic unused_hi;

    always_comb begin
        ovf       = word[OVF_BIT];
        wptr_eff  = word[ADDR_W-1:0] & ~FLAG_MASK;
        jump_ptr  = wptr_eff + STEP;
        unused_hi = &{1'b0, word[WORD_W-1:ADDR_W]};
    end
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
    import irq_ring_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  base_idx,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output vec_words_t        words
);
    localparam int CNT_W = $clog2(WORDS_PER_VEC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS_PER_VEC - 1);

    logic             issuing_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [CNT_W-1:0] slot_q;
    logic [WORD_W-1:0] cap_q [WORDS_PER_VEC];

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing_q <= 1'b0;
            cnt_q     <= '0;
            pend_q    <= 1'b0;
            slot_q    <= '0;
            done      <= 1'b0;
        end else begin
            if (start) begin
                issuing_q <= 1'b1;
                cnt_q     <= '0;
            end else if (issuing_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) issuing_q <= 1'b0;
            end
            pend_q <= issuing_q;
            slot_q <= cnt_q;
            done   <= pend_q && (slot_q == LAST);
        end
    end

    always_comb begin
        rd_en   = issuing_q;
        rd_addr = base_idx + IDX_W'(cnt_q);
    end

    for (genvar g = 0; g < WORDS_PER_VEC; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)
                cap_q[g] <= '0;
            else if (pend_q && (slot_q == CNT_W'(g)))
                cap_q[g] <= rd_data;
        end
        assign words[g] = cap_q[g];
    end
endmodule

// File: rtl/irq_vec_decode.sv
module irq_vec_decode
    import irq_ring_pkg::*;
(
    input  vec_words_t words,
    output irq_entry_t entry,
    output logic       needs_credit
);
    logic unused_bits;

    always_comb begin
        entry.src_id   = words[0][7:0];
        entry.src_data = words[1][27:0];
        entry.ring_id  = words[2][7:0];
        entry.vmid     = words[2][15:8];
        entry.pasid    = words[2][31:16];
        needs_credit   = is_fault_src(entry.src_id) && (entry.pasid != 16'd0);
        unused_bits    = &{1'b0, words[0][31:8], words[1][31:28], words[3]};
    end
endmodule

// File: rtl/irq_ring_consumer.sv
module irq_ring_consumer
    import irq_ring_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       wptr_word,
    output logic              mem_rd_en,
    output logic [ADDR_W-3:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              cred_req_valid,
    output logic [15:0]       cred_req_pasid,
    input  logic              cred_rsp_valid,
    input  logic              cred_rsp_grant,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_src_id,
    output logic [27:0]       out_src_data,
    output logic [7:0]        out_ring_id,
    output logic [7:0]        out_vmid,
    output logic [15:0]       out_pasid,
    output logic              rptr_wb_valid,
    output logic [ADDR_W-1:0] rptr_wb,
    output logic              ovf_clear
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(VEC_BYTES);

    logic              ovf;
    logic [ADDR_W-1:0] wptr_eff;
    logic [ADDR_W-1:0] jump_ptr;
    logic              fetch_start;
    logic              fetch_done;
    vec_words_t        words;
    irq_entry_t        entry;
    logic              needs_credit;

    cons_state_t       state_q;
    logic [ADDR_W-1:0] rptr_q;
    logic              dirty_q;
    logic              wb_valid_q;
    logic [ADDR_W-1:0] wb_q;
    logic              ovf_clr_q;

    irq_wptr_cond #(.ADDR_W(ADDR_W)) u_wcond (
        .word     (wptr_word),
        .ovf      (ovf),
        .wptr_eff (wptr_eff),
        .jump_ptr (jump_ptr)
    );

    irq_vec_fetch #(.IDX_W(IDX_W)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .start    (fetch_start),
        .base_idx (rptr_q[ADDR_W-1:2]),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .rd_data  (mem_rd_data),
        .done     (fetch_done),
        .words    (words)
    );

    irq_vec_decode u_dec (
        .words        (words),
        .entry        (entry),
        .needs_credit (needs_credit)
    );

    always_comb fetch_start = (state_q == ST_IDLE) && (ovf || (rptr_q != wptr_eff));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            rptr_q     <= '0;
            dirty_q    <= 1'b0;
            wb_valid_q <= 1'b0;
            wb_q       <= '0;
            ovf_clr_q  <= 1'b0;
        end else begin
            wb_valid_q <= 1'b0;
            ovf_clr_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ovf) begin
                        rptr_q    <= jump_ptr;
                        dirty_q   <= 1'b1;
                        ovf_clr_q <= 1'b1;
                        state_q   <= ST_FETCH;
                    end else if (rptr_q != wptr_eff) begin
                        state_q <= ST_FETCH;
                    end else if (dirty_q) begin
                        wb_valid_q <= 1'b1;
                        wb_q       <= rptr_q;
                        dirty_q    <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) state_q <= ST_SCREEN;
                end
                ST_SCREEN: begin
                    state_q <= needs_credit ? ST_CREDIT : ST_EMIT;
                end
                ST_CREDIT: begin
                    if (cred_rsp_valid) begin
                        if (cred_rsp_grant) begin
                            state_q <= ST_EMIT;
                        end else begin
                            rptr_q  <= rptr_q + STEP;
                            dirty_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        rptr_q  <= rptr_q + STEP;
                        dirty_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cred_req_valid = (state_q == ST_CREDIT);
        cred_req_pasid = entry.pasid;
        out_valid      = (state_q == ST_EMIT);
        out_src_id     = entry.src_id;
        out_src_data   = entry.src_data;
        out_ring_id    = entry.ring_id;
        out_vmid       = entry.vmid;
        out_pasid      = entry.pasid;
        rptr_wb_valid  = wb_valid_q;
        rptr_wb        = wb_q;
        ovf_clear      = ovf_clr_q;
    end
endmodule

// File: rtl/irq_ring_consumer_chk.sv
module irq_ring_consumer_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd_en,
    input logic        cred_req_valid,
    input logic [15:0] cred_req_pasid,
    input logic        cred_rsp_valid,
    input logic        out_valid,
    input logic        out_ready,
    input logic [67:0] out_bundle,
    input logic        rptr_wb_valid,
    input logic        ovf_clear
);
    // R9: a stalled output keeps its contents
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bundle)));

    // R8: a completed handshake retires the vector
    p_retire_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

    // R6: request stays up and stable until answered
    p_credit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cred_req_valid && !cred_rsp_valid) |=> (cred_req_valid && $stable(cred_req_pasid)));

    // R6: id zero never asks for credit
    p_credit_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        cred_req_valid |-> (cred_req_pasid != 16'd0));

    // R7: a vector under credit check is not yet presented
    p_credit_before_out_r7: assert property (@(posedge clk) disable iff (rst)
        cred_req_valid |-> !out_valid);

    // R10: write-back is a single-cycle pulse
    p_wb_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rptr_wb_valid |=> !rptr_wb_valid);

    // R3: overflow clear comes alone, with no output or write-back alongside
    p_ovf_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_clear |-> (!out_valid && !rptr_wb_valid && !cred_req_valid));

    // R3: clear is a single-cycle pulse
    p_ovf_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_clear |=> !ovf_clear);

    // R4: memory is only read while no vector is pending downstream
    p_rd_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (!out_valid && !cred_req_valid));
endmodule

bind irq_ring_consumer irq_ring_consumer_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mem_rd_en      (mem_rd_en),
    .cred_req_valid (cred_req_valid),
    .cred_req_pasid (cred_req_pasid),
    .cred_rsp_valid (cred_rsp_valid),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_bundle     ({out_src_id, out_src_data, out_ring_id, out_vmid, out_pasid}),
    .rptr_wb_valid  (rptr_wb_valid),
    .ovf_clear      (ovf_clear)
);

// File: tb/irq_ring_consumer_tb_top.sv
module irq_ring_consumer_tb_top;
    localparam int ADDR_W = 8;
    localparam int NWORDS = 1 << (ADDR_W - 2);
    localparam int NVEC   = NWORDS / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       wptr_word = '0;
    logic              mem_rd_en;
    logic [ADDR_W-3:0] mem_rd_addr;
    logic [31:0]       mem_rd_data = '0;
    logic              cred_req_valid;
    logic [15:0]       cred_req_pasid;
    logic              cred_rsp_valid = 1'b0;
    logic              cred_rsp_grant = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [7:0]        out_src_id;
    logic [27:0]       out_src_data;
    logic [7:0]        out_ring_id;
    logic [7:0]        out_vmid;
    logic [15:0]       out_pasid;
    logic              rptr_wb_valid;
    logic [ADDR_W-1:0] rptr_wb;
    logic              ovf_clear;

    logic [31:0] mem [NWORDS];

    int n_checks = 0;
    int n_fail   = 0;
    int rec_n    = 0;
    int wb_cnt   = 0;
    int ovf_cnt  = 0;
    int req_cnt  = 0;
    logic [7:0]  rec_src   [64];
    logic [27:0] rec_data  [64];
    logic [7:0]  rec_ring  [64];
    logic [7:0]  rec_vmid  [64];
    logic [15:0] rec_pasid [64];
    logic [ADDR_W-1:0] wb_last = '0;
    logic [15:0] last_req_pasid = '0;

    always #5 clk = ~clk;

    irq_ring_consumer #(.ADDR_W(ADDR_W)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .wptr_word      (wptr_word),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_data    (mem_rd_data),
        .cred_req_valid (cred_req_valid),
        .cred_req_pasid (cred_req_pasid),
        .cred_rsp_valid (cred_rsp_valid),
        .cred_rsp_grant (cred_rsp_grant),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_src_id     (out_src_id),
        .out_src_data   (out_src_data),
        .out_ring_id    (out_ring_id),
        .out_vmid       (out_vmid),
        .out_pasid      (out_pasid),
        .rptr_wb_valid  (rptr_wb_valid),
        .rptr_wb        (rptr_wb),
        .ovf_clear      (ovf_clear)
    );

    // synchronous ring memory model, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    // monitor, sampling at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                rec_src[rec_n]   <= out_src_id;
                rec_data[rec_n]  <= out_src_data;
                rec_ring[rec_n]  <= out_ring_id;
                rec_vmid[rec_n]  <= out_vmid;
                rec_pasid[rec_n] <= out_pasid;
                rec_n = rec_n + 1;
            end
            if (rptr_wb_valid) begin
                wb_cnt  = wb_cnt + 1;
                wb_last = rptr_wb;
            end
            if (ovf_clear) ovf_cnt = ovf_cnt + 1;
        end
    end

    // credit responder: answers two cycles later, grants even ids
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cred_req_valid) begin
                req_cnt = req_cnt + 1;
                last_req_pasid = cred_req_pasid;
                repeat (2) @(posedge clk);
                #1;
                cred_rsp_valid = 1'b1;
                cred_rsp_grant = ~cred_req_pasid[0];
                @(posedge clk);
                #1;
                cred_rsp_valid = 1'b0;
                cred_rsp_grant = 1'b0;
            end
        end
    end

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive_wptr(input logic [31:0] w);
        @(posedge clk);
        #1;
        wptr_word = w;
    endtask

    task automatic wait_wb(input int n);
        int guard;
        guard = 0;
        while (wb_cnt < n && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic fill_ring();
        for (int v = 0; v < NVEC; v++) begin
            mem[4*v+0] = {24'h5A5A5A, 8'(8'h40 + v)};
            mem[4*v+1] = {4'hF, 28'(28'h0101011 * (v + 1))};
            mem[4*v+2] = {16'h0000, 8'(8'hC0 + v), 8'(v + 1)};
            mem[4*v+3] = 32'hDEAD0000 + 32'(v);
        end
        // fault vectors for the prescreen scenario
        mem[4*2+0] = {24'h0, 8'd146};  mem[4*2+2] = {16'd5, 8'h12, 8'h03};
        mem[4*3+0] = {24'h0, 8'd147};  mem[4*3+2] = {16'd6, 8'h13, 8'h04};
        mem[4*4+0] = {24'h0, 8'd146};  mem[4*4+2] = {16'd0, 8'h14, 8'h05};
        mem[4*5+0] = {24'h0, 8'd10};   mem[4*5+2] = {16'd7, 8'h15, 8'h06};
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1 out_valid", 64'(out_valid), 64'd0);
        check_eq("R1 cred_req_valid", 64'(cred_req_valid), 64'd0);
        check_eq("R1 mem_rd_en", 64'(mem_rd_en), 64'd0);
        check_eq("R1 wb/ovf pulses", 64'({rptr_wb_valid, ovf_clear}), 64'd0);
    endtask

    task automatic t_basic();
        rec_n = 0;
        drive_wptr(32'd32);
        wait_wb(1);
        check_eq("R8 two vectors out", 64'(rec_n), 64'd2);
        check_eq("R4 first src id", 64'(rec_src[0]), 64'h40);
        check_eq("R5 src id", 64'(rec_src[1]), 64'h41);
        check_eq("R5 src data", 64'(rec_data[1]), 64'(28'h0101011 * 2));
        check_eq("R5 ring id", 64'(rec_ring[1]), 64'h02);
        check_eq("R5 vmid", 64'(rec_vmid[1]), 64'hC1);
        check_eq("R5 pasid", 64'(rec_pasid[1]), 64'h0);
        check_eq("R10 write-back value", 64'(wb_last), 64'd32);
    endtask

    task automatic t_high_bits();
        rec_n = 0;
        drive_wptr(32'hABCD_0F20);   // low 8 bits 0x20 = 32, upper bits ignored
        repeat (30) @(negedge clk);
        check_eq("R2 no fetch on equal pointers", 64'(rec_n), 64'd0);
        check_eq("R10 no spurious write-back", 64'(wb_cnt), 64'd1);
    endtask

    task automatic t_prescreen();
        rec_n = 0;
        drive_wptr(32'd96);
        wait_wb(2);
        check_eq("R7 denied fault dropped", 64'(rec_n), 64'd3);
        check_eq("R6 granted fault passes", 64'(rec_src[0]), 64'd147);
        check_eq("R6 granted pasid", 64'(rec_pasid[0]), 64'd6);
        check_eq("R6 zero pasid passes", 64'(rec_src[1]), 64'd146);
        check_eq("R6 other source passes", 64'(rec_src[2]), 64'd10);
        check_eq("R6 request count", 64'(req_cnt), 64'd2);
        check_eq("R7 pointer past drop", 64'(wb_last), 64'd96);
    endtask

    task automatic t_stall();
        logic [7:0]  held_src;
        logic [27:0] held_data;
        int guard;
        rec_n = 0;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        drive_wptr(32'd112);
        guard = 0;
        while (!out_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        held_src  = out_src_id;
        held_data = out_src_data;
        repeat (10) @(negedge clk);
        check_eq("R9 valid held", 64'(out_valid), 64'd1);
        check_eq("R9 fields held", 64'({out_src_id, out_src_data}), 64'({held_src, held_data}));
        check_eq("R9 no fetch while stalled", 64'(mem_rd_en), 64'd0);
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        wait_wb(3);
        check_eq("R8 single vector after stall", 64'(rec_n), 64'd1);
        check_eq("R8 stalled vector src", 64'(rec_src[0]), 64'h46);
        check_eq("R10 write-back after stall", 64'(wb_last), 64'd112);
    endtask

    task automatic t_wrap();
        rec_n = 0;
        drive_wptr(32'd240);
        wait_wb(4);
        drive_wptr(32'd16);
        wait_wb(5);
        check_eq("R11 vectors across wrap", 64'(rec_n), 64'd10);
        check_eq("R11 last slot", 64'(rec_src[8]), 64'h4F);
        check_eq("R11 slot zero after wrap", 64'(rec_src[9]), 64'h40);
        check_eq("R11 wrapped write-back", 64'(wb_last), 64'd16);
    endtask

    task automatic t_overflow();
        int guard;
        rec_n = 0;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        drive_wptr(32'd32);
        guard = 0;
        while (!out_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1;
        wptr_word = 32'd33;          // overflow flag with write pointer 32
        out_ready = 1'b1;
        guard = 0;
        while (ovf_cnt == 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check_eq("R3 no write-back at jump", 64'(wb_cnt), 64'd5);
        @(posedge clk);
        #1;
        wptr_word = 32'd32;
        wait_wb(6);
        repeat (20) @(negedge clk);
        check_eq("R3 single clear pulse", 64'(ovf_cnt), 64'd1);
        check_eq("R3 vectors after jump", 64'(rec_n), 64'd16);
        check_eq("R3 stalled vector first", 64'(rec_src[0]), 64'h41);
        check_eq("R3 oldest intact next", 64'(rec_src[1]), 64'd147);
        check_eq("R11 jump path wraps", 64'(rec_src[15]), 64'h41);
        check_eq("R10 one write-back after drain", 64'(wb_cnt), 64'd6);
        check_eq("R10 drained pointer", 64'(wb_last), 64'd32);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished run");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill_ring();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_basic();
        t_high_bits();
        t_prescreen();
        t_stall();
        t_wrap();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule